// File: doc/BRIEF.md
# Paced Four-Channel DAC Scan Sequencer

This block hands samples to four 12-bit DAC channels, one channel per update event, stepping through a contiguous window of channels bounded by a first and a last channel. Each channel has two latches in series: an input latch that takes the incoming sample, and an output latch that drives the DAC code. In the normal transfer mode a sample reaches the output as soon as it is latched. In the simultaneous transfer mode, samples wait in the input latches. All four outputs then change together when channel 3 receives its sample.

Update events come from one of two sources. In paced mode, a falling edge on the external pacer input counts as an event when the external gate is high and the hold bit is clear. Each such event takes one sample from an external FIFO. In direct mode, the pacer is ignored. Each host data write is then an event that carries its own 12-bit value, and the FIFO is not touched. After each event the channel pointer steps to the next channel. After the last channel of the window it returns to the first one.

Top module: `dac_scan_seq`

## Requirements
- R1: Reset clears all four input latches, all four output latches, both window limits and the channel pointer (pointer at channel 0).
- R2: A write to the window register takes the first channel from bits 1..0 and the last channel from bits 5..4. The register reads back as {2'b00, last, 2'b00, first}, one cycle after the write.
- R3: Successive events write the channels from the first channel to the last channel in ascending order, with none skipped. After the last channel, the pointer returns to the first channel.
- R4: A window write reloads the pointer to the new first channel. An event in the same cycle lands on the channel the pointer held before that write.
- R5: With simultaneous mode clear, the written channel's output carries the new sample on the clock edge at which the event is taken. No output changes in a cycle without an event.
- R6: With simultaneous mode set, an event on channels 0 to 2 changes only the input latch, so the outputs hold. An event on channel 3 moves all four input latches, including the new channel 3 sample, to the outputs on the same edge.
- R7: In direct mode (paced_mode low), a host_wr pulse writes host_data to the current channel and advances the pointer. The pacer is ignored and fifo_pop stays low.
- R8: In paced mode, only a high-to-low transition of pacer_in, seen at a clock edge, counts as an event, and only while gate_in is high at that edge.
- R9: While start_hold is high, pacer edges are ignored.
- R10: An accepted pacer edge while fifo_empty is high causes no pop. It changes no latch and does not advance the pointer.
- R11: fifo_pop is high exactly in the cycle of an accepted pacer event with data available. The sample written is fifo_data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chsel_wr | input | 1 | Window register write strobe |
| chsel_wdata | input | 8 | Window register write data |
| chsel_rdata | output | 8 | Window register read-back |
| paced_mode | input | 1 | 1: pacer-driven events, 0: direct host writes |
| start_hold | input | 1 | Holds the pacer off while high |
| simul_en | input | 1 | Simultaneous transfer on channel 3 |
| pacer_in | input | 1 | External pacer, falling edge active |
| gate_in | input | 1 | Active-high pacer gate |
| host_wr | input | 1 | Direct-mode write pulse (low byte complete) |
| host_data | input | 12 | Direct-mode sample |
| fifo_empty | input | 1 | FIFO has no sample |
| fifo_data | input | 12 | Sample at the FIFO head |
| fifo_pop | output | 1 | Takes the FIFO head |
| dac_flat | output | 48 | Channel n code at bits [12n+11:12n] |

## Verification
A window register write and an update event can occur on the same clock edge. The bench provokes this by raising chsel_wr in the cycle in which the pacer falling edge is sampled. It then checks that the sample lands on the old pointer's channel and that the next sample lands on the new first channel. A second coincidence is a simultaneous-mode event on channel 3. Here the new sample and the transfer of the other three latches happen on the same edge. The bench judges both cases against its behavioural model on every cycle, and also against literal expected codes.

// File: rtl/dac_scan_seq_pkg.sv
package dac_scan_seq_pkg;
    parameter int unsigned CH_NUM = 4;
    parameter int unsigned CODE_W = 12;
    localparam int unsigned PTR_W = $clog2(CH_NUM);
    localparam int unsigned FLAT_W = CH_NUM * CODE_W;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        ptr_t first;
        ptr_t last;
        ptr_t cur;
    } window_t;

    typedef struct packed {
        code_t held;
        code_t shown;
    } lane_t;
endpackage

// File: rtl/dac_seq_tick.sv
module dac_seq_tick
    import dac_scan_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  paced_mode,
    input  logic  start_hold,
    input  logic  pacer_in,
    input  logic  gate_in,
    input  logic  host_wr,
    input  code_t host_data,
    input  logic  fifo_empty,
    input  code_t fifo_data,
    output logic  fifo_pop,
    output logic  evt_valid,
    output code_t evt_data
);
    logic prev_d, prev_q;
    logic fall, paced_evt, direct_evt;

    always_comb begin
        fall       = prev_q & ~pacer_in;
        paced_evt  = paced_mode & gate_in & ~start_hold & fall;
        fifo_pop   = paced_evt & ~fifo_empty;
        direct_evt = ~paced_mode & host_wr;
        evt_valid  = fifo_pop | direct_evt;
        evt_data   = paced_mode ? fifo_data : host_data;
        prev_d     = pacer_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dac_seq_ptr.sv
module dac_seq_ptr
    import dac_scan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  ptr_t cfg_first,
    input  ptr_t cfg_last,
    input  logic advance,
    output ptr_t cur_ptr,
    output ptr_t first_ch,
    output ptr_t last_ch
);
    window_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (advance) begin
            if (win_q.cur == win_q.last) win_d.cur = win_q.first;
            else                         win_d.cur = ptr_t'(win_q.cur + 1'b1);
        end
        if (cfg_wr) begin
            win_d.first = cfg_first;
            win_d.last  = cfg_last;
            win_d.cur   = cfg_first;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign cur_ptr  = win_q.cur;
    assign first_ch = win_q.first;
    assign last_ch  = win_q.last;
endmodule

// File: rtl/dac_seq_latch_bank.sv
module dac_seq_latch_bank
    import dac_scan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  ptr_t              wr_ptr,
    input  code_t             wr_data,
    input  logic              simul_en,
    output logic [FLAT_W-1:0] codes_flat
);
    localparam ptr_t LAST_CH = ptr_t'(CH_NUM - 1);

    lane_t lane_d [CH_NUM];
    lane_t lane_q [CH_NUM];
    logic  bulk_xfer;

    assign bulk_xfer = simul_en & wr_valid & (wr_ptr == LAST_CH);

    for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_lane
        logic hit;
        assign hit = wr_valid & (wr_ptr == ptr_t'(ch));

        always_comb begin
            lane_d[ch] = lane_q[ch];
            if (hit) lane_d[ch].held = wr_data;
            if (simul_en) begin
                if (bulk_xfer) lane_d[ch].shown = lane_d[ch].held;
            end else if (hit) begin
                lane_d[ch].shown = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) lane_q[ch] <= '0;
            else        lane_q[ch] <= lane_d[ch];
        end

        assign codes_flat[ch*CODE_W +: CODE_W] = lane_q[ch].shown;
    end
endmodule

// File: rtl/dac_scan_seq.sv
module dac_scan_seq
    import dac_scan_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chsel_wr,
    input  logic [7:0]        chsel_wdata,
    output logic [7:0]        chsel_rdata,
    input  logic              paced_mode,
    input  logic              start_hold,
    input  logic              simul_en,
    input  logic              pacer_in,
    input  logic              gate_in,
    input  logic              host_wr,
    input  logic [CODE_W-1:0] host_data,
    input  logic              fifo_empty,
    input  logic [CODE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic [FLAT_W-1:0] dac_flat
);
    logic  evt_valid;
    code_t evt_data;
    ptr_t  cur_ptr, first_ch, last_ch;

    dac_seq_tick u_tick (
        .clk(clk), .rst_n(rst_n), .paced_mode(paced_mode), .start_hold(start_hold),
        .pacer_in(pacer_in), .gate_in(gate_in), .host_wr(host_wr),
        .host_data(host_data), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .evt_valid(evt_valid), .evt_data(evt_data)
    );

    dac_seq_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(chsel_wr),
        .cfg_first(chsel_wdata[1:0]), .cfg_last(chsel_wdata[5:4]),
        .advance(evt_valid), .cur_ptr(cur_ptr),
        .first_ch(first_ch), .last_ch(last_ch)
    );

    dac_seq_latch_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_valid(evt_valid), .wr_ptr(cur_ptr),
        .wr_data(evt_data), .simul_en(simul_en), .codes_flat(dac_flat)
    );

    assign chsel_rdata = {2'b00, last_ch, 2'b00, first_ch};
endmodule

// File: rtl/dac_scan_seq_chk.sv
module dac_scan_seq_chk
    import dac_scan_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chsel_wr,
    input logic [7:0]        chsel_wdata,
    input logic [7:0]        chsel_rdata,
    input logic              paced_mode,
    input logic              start_hold,
    input logic              simul_en,
    input logic              pacer_in,
    input logic              gate_in,
    input logic              host_wr,
    input logic [CODE_W-1:0] host_data,
    input logic              fifo_empty,
    input logic [CODE_W-1:0] fifo_data,
    input logic              fifo_pop,
    input logic [FLAT_W-1:0] dac_flat
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (dac_flat == '0));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chsel_wr |=> (chsel_rdata == {2'b00, $past(chsel_wdata[5:4]), 2'b00, $past(chsel_wdata[1:0])}));

    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_pop && !(host_wr && !paced_mode)) |=> $stable(dac_flat));

    assert_direct_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !paced_mode |-> !fifo_pop);

    assert_gate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_in |-> !fifo_pop);

    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_hold |-> !fifo_pop);

    assert_no_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_pop);

    assert_pop_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!pacer_in && $past(pacer_in)));
endmodule

bind dac_scan_seq dac_scan_seq_chk chk_i (.*);

// File: tb/dac_scan_seq_tb_top.sv
module dac_scan_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chsel_wr = 1'b0;
    logic [7:0]  chsel_wdata = '0;
    logic [7:0]  chsel_rdata;
    logic        paced_mode = 1'b1;
    logic        start_hold = 1'b0;
    logic        simul_en = 1'b0;
    logic        pacer_in = 1'b0;
    logic        gate_in = 1'b1;
    logic        host_wr = 1'b0;
    logic [11:0] host_data = '0;
    logic        fifo_empty = 1'b1;
    logic [11:0] fifo_data = '0;
    logic        fifo_pop;
    logic [47:0] dac_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] fifo_q[$];
    int m_held[4];
    int m_shown[4];
    int m_cur, m_first, m_last;
    bit m_prev;

    always #10 clk = ~clk;

    dac_scan_seq dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int chan(input int n);
        return int'(dac_flat[n*12 +: 12]);
    endfunction

    // Behavioural reference, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_held[i]) begin m_held[i] = 0; m_shown[i] = 0; end
            m_cur = 0; m_first = 0; m_last = 0; m_prev = 1'b0;
        end else begin
            bit accept, pop, dir;
            int val;
            accept = paced_mode && gate_in && !start_hold && m_prev && !pacer_in;
            pop = accept && (fifo_q.size() > 0);
            dir = !paced_mode && host_wr;
            val = pop ? int'(fifo_q[0]) : int'(host_data);
            if (pop || dir) begin
                m_held[m_cur] = val;
                if (simul_en) begin
                    if (m_cur == 3) foreach (m_shown[i]) m_shown[i] = m_held[i];
                end else begin
                    m_shown[m_cur] = val;
                end
                m_cur = (m_cur == m_last) ? m_first : (m_cur + 1) % 4;
            end
            if (chsel_wr) begin
                m_first = int'(chsel_wdata[1:0]);
                m_last  = int'(chsel_wdata[5:4]);
                m_cur   = m_first;
            end
            m_prev = pacer_in;
            if (pop) begin
                void'(fifo_q.pop_front());
                fifo_empty <= (fifo_q.size() == 0);
                fifo_data  <= (fifo_q.size() > 0) ? fifo_q[0] : 12'h000;
            end
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_pop;
            exp_pop = paced_mode && gate_in && !start_hold && m_prev && !pacer_in && !fifo_empty;
            check("R11 pop", int'(fifo_pop), int'(exp_pop));
            for (int n = 0; n < 4; n++) check("R5/R6 model output", chan(n), m_shown[n]);
            check("R2 model readback", int'(chsel_rdata), (m_last << 4) | m_first);
        end
    end

    task automatic push(input logic [11:0] v);
        fifo_q.push_back(v);
        fifo_empty = 1'b0;
        fifo_data  = fifo_q[0];
    endtask

    task automatic tick(input bit with_cfg = 1'b0, input logic [7:0] cfg = 8'h00);
        @(posedge clk); #2 pacer_in = 1'b1;
        @(posedge clk); #2 pacer_in = 1'b0;
        chsel_wr = with_cfg; chsel_wdata = cfg;
        @(posedge clk); #2 chsel_wr = 1'b0;
    endtask

    task automatic set_window(input logic [7:0] v);
        @(posedge clk); #2 chsel_wr = 1'b1; chsel_wdata = v;
        @(posedge clk); #2 chsel_wr = 1'b0;
    endtask

    task automatic host_write(input logic [11:0] v);
        @(posedge clk); #2 host_wr = 1'b1; host_data = v;
        @(posedge clk); #2 host_wr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", int'(dac_flat == '0), 1);
        check("R1 window after reset", int'(chsel_rdata), 0);

        set_window(8'hFF);
        @(negedge clk) check("R2 readback masks", int'(chsel_rdata), 8'h33);
        set_window(8'h21);
        @(negedge clk) check("R2 readback", int'(chsel_rdata), 8'h21);

        push(12'h111); push(12'h222); push(12'h333);
        tick();
        @(negedge clk) check("R5 ch1 first sample", chan(1), 12'h111);
        tick();
        @(negedge clk) check("R3 ch2 next", chan(2), 12'h222);
        tick();
        @(negedge clk) check("R3 wrap to ch1", chan(1), 12'h333);
        check("R3 ch0 untouched", chan(0), 0);
        check("R3 ch3 untouched", chan(3), 0);

        tick();
        @(negedge clk) check("R10 empty tick ch2 held", chan(2), 12'h222);
        push(12'h444);
        tick();
        @(negedge clk) check("R10 pointer not advanced", chan(2), 12'h444);

        start_hold = 1'b1;
        push(12'h555);
        tick();
        @(negedge clk) check("R9 hold blocks", chan(1), 12'h333);
        start_hold = 1'b0;
        tick();
        @(negedge clk) check("R9 release", chan(1), 12'h555);

        gate_in = 1'b0;
        push(12'h666);
        tick();
        @(negedge clk) check("R8 gate low blocks", chan(2), 12'h444);
        gate_in = 1'b1;
        tick();
        @(negedge clk) check("R8 gate high", chan(2), 12'h666);

        // window rewrite in the same cycle as an event
        push(12'h777);
        tick(1'b1, 8'h33);
        @(negedge clk) check("R4 event on old pointer", chan(1), 12'h777);
        check("R4 new window", int'(chsel_rdata), 8'h33);
        push(12'h888);
        tick();
        @(negedge clk) check("R4 reload to first", chan(3), 12'h888);

        set_window(8'h30);
        simul_en = 1'b1;
        push(12'hA00); push(12'hA01); push(12'hA02); push(12'hA03);
        tick();
        @(negedge clk) check("R6 ch0 held back", chan(0), 0);
        tick(); tick();
        @(negedge clk) check("R6 ch2 held back", chan(2), 12'h666);
        tick();
        @(negedge clk);
        for (int n = 0; n < 4; n++) check("R6 bulk transfer", chan(n), 12'hA00 + n);

        simul_en = 1'b0;
        paced_mode = 1'b0;
        set_window(8'h32);
        host_write(12'hB00);
        @(negedge clk) check("R7 direct ch2", chan(2), 12'hB00);
        push(12'hC00);
        tick();
        @(negedge clk) check("R7 pacer ignored", chan(3), 12'hA03);
        check("R7 fifo kept", int'(fifo_empty), 0);
        host_write(12'hB01);
        @(negedge clk) check("R7 direct ch3", chan(3), 12'hB01);
        host_write(12'hB02);
        @(negedge clk) check("R7 direct wrap", chan(2), 12'hB02);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule